// File: doc/BRIEF.md
# Raster Position and Timing Readback Unit

This block keeps the live scan position of a display raster and exposes it, together with a few derived timing words, through a simple word-addressed register port. A horizontal counter advances once for every pixel-clock enable and wraps at the end of each line, stepping a vertical counter that wraps at the end of the frame. A single-cycle frame-start strobe marks the return to the origin.

Software can halt both counters by writing a freeze bit and release them by clearing it. The current resolution is loaded from a separate configuration strobe; from it the block derives the last valid coordinate on each axis and the horizontal and vertical pixel-enable windows, all of which read back as two 12-bit fields packed into one 32-bit word. All port signals are plain control and status pins; reads are combinational from the addressed word and need no handshake.

Top module: `raster_pos_regs`

## Requirements
- R1: After reset the position is x = 0, y = 0, the counters are not frozen, the resolution is 640 by 480 and `frame_start` is low.
- R2: Word offset 0 reads the position word: freeze state in bit 31, y in bits 23..12, x in bits 11..0, every other bit 0.
- R3: When not frozen, each cycle with `pix_en` high advances x by one; at x = xres-1 the next advance sets x to 0 and increments y, and at y = yres-1 that same advance sets y to 0.
- R4: In a cycle with `pix_en` low the position does not change.
- R5: A write to offset 0 sets the freeze state to bit 31 of the write data from the next cycle on; while frozen the position does not change; the other write bits never alter the position.
- R6: Word offset 1 reads ((yres-1) << 12) | (xres-1).
- R7: Word offset 2 reads the horizontal enable window: on value 0 in bits 23..12 and off value xres-1 in bits 11..0.
- R8: Word offset 3 reads the vertical enable window: on value 0 in bits 23..12 and off value yres-1 in bits 11..0.
- R9: `frame_start` is high for exactly the cycle that follows the clock edge at which both x and y wrap to 0, and low otherwise.
- R10: A `cfg_load` cycle with both `cfg_xres` and `cfg_yres` non-zero takes the new resolution and returns the position to 0,0 at that edge, ahead of any advance; a `cfg_load` with either value zero is ignored.
- R11: Offsets 4 to 15 read 0, and writes to any offset other than 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel clock enable, one advance per high cycle |
| cfg_load | input | 1 | Strobe that loads the resolution inputs |
| cfg_xres | input | 12 | Pixels per line for a load |
| cfg_yres | input | 12 | Lines per frame for a load |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| frame_start | output | 1 | One-cycle strobe after the wrap to the origin |

## Verification
The assertions take for granted that the resolution inputs are only sampled on a `cfg_load` cycle and that no more than one write is presented per cycle; the bench changes them only alongside a strobe. They also assume the frame-start strobe is judged against a position that was not reloaded in the same cycle, so the stimulus never raises `cfg_load` together with a wrap. The bench drives every input half a cycle away from the active edge and writes freeze only while `pix_en` is low, so the advance that coincides with a freeze write is never part of an expected value.

// File: rtl/vtp_pkg.sv
package vtp_pkg;

  localparam int COORD_W   = 12;
  localparam int WORD_W    = 32;
  localparam int OFS_W     = 4;
  localparam int HOLD_BIT  = 31;

  typedef enum logic [OFS_W-1:0] {
    OFS_POS  = 4'd0,
    OFS_MAX  = 4'd1,
    OFS_HWIN = 4'd2,
    OFS_VWIN = 4'd3
  } reg_ofs_e;

  // Two coordinate fields in one word: upper field above lower field.
  function automatic logic [WORD_W-1:0] pack_pair(
    input logic [COORD_W-1:0] hi,
    input logic [COORD_W-1:0] lo
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[2*COORD_W-1:COORD_W] = hi;
    w[COORD_W-1:0]         = lo;
    return w;
  endfunction

endpackage

// File: rtl/vtp_res_cfg.sv
module vtp_res_cfg #(
  parameter int CW       = vtp_pkg::COORD_W,
  parameter int DEF_XRES = 640,
  parameter int DEF_YRES = 480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] xres_in,
  input  logic [CW-1:0] yres_in,
  output logic          accept,
  output logic [CW-1:0] xlast,
  output logic [CW-1:0] ylast
);

  localparam logic [CW-1:0] DEF_XLAST = CW'(DEF_XRES - 1);
  localparam logic [CW-1:0] DEF_YLAST = CW'(DEF_YRES - 1);

  assign accept = load && (xres_in != '0) && (yres_in != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlast <= DEF_XLAST;
      ylast <= DEF_YLAST;
    end else if (accept) begin
      xlast <= xres_in - CW'(1);
      ylast <= yres_in - CW'(1);
    end
  end

endmodule

// File: rtl/vtp_axis_ctr.sv
module vtp_axis_ctr #(
  parameter int CW = vtp_pkg::COORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] cnt,
  output logic          at_last
);

  assign at_last = (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= at_last ? '0 : cnt + CW'(1);
    end
  end

endmodule

// File: rtl/vtp_readback.sv
module vtp_readback #(
  parameter int CW = vtp_pkg::COORD_W,
  parameter int DW = vtp_pkg::WORD_W,
  parameter int AW = vtp_pkg::OFS_W,
  parameter int HB = vtp_pkg::HOLD_BIT
) (
  input  logic [AW-1:0] addr,
  input  logic          frozen,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  input  logic [CW-1:0] xlast,
  input  logic [CW-1:0] ylast,
  output logic [DW-1:0] rdata
);
  import vtp_pkg::*;

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_POS: begin
        rdata     = pack_pair(pos_y, pos_x);
        rdata[HB] = frozen;
      end
      OFS_MAX:  rdata = pack_pair(ylast, xlast);
      OFS_HWIN: rdata = pack_pair('0, xlast);
      OFS_VWIN: rdata = pack_pair('0, ylast);
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/raster_pos_regs.sv
module raster_pos_regs #(
  parameter int CW       = vtp_pkg::COORD_W,
  parameter int DW       = vtp_pkg::WORD_W,
  parameter int AW       = vtp_pkg::OFS_W,
  parameter int DEF_XRES = 640,
  parameter int DEF_YRES = 480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_xres,
  input  logic [CW-1:0] cfg_yres,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          frame_start
);
  import vtp_pkg::*;

  localparam int NAXIS = 2;

  logic          frozen;
  logic          cfg_ok;
  logic [CW-1:0] xlast, ylast;
  logic [CW-1:0] pos_x, pos_y;
  logic          adv;
  logic [NAXIS-1:0]         ax_step, ax_end;
  logic [NAXIS-1:0][CW-1:0] ax_last, ax_cnt;
  logic          unused_wdata;

  assign unused_wdata = ^bus_wdata;

  vtp_res_cfg #(.CW(CW), .DEF_XRES(DEF_XRES), .DEF_YRES(DEF_YRES)) i_res (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .xres_in(cfg_xres), .yres_in(cfg_yres),
    .accept(cfg_ok), .xlast(xlast), .ylast(ylast)
  );

  // Freeze control: only the hold bit of a write to the position word counts.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frozen <= 1'b0;
    end else if (bus_we && (bus_addr == OFS_POS)) begin
      frozen <= bus_wdata[HOLD_BIT];
    end
  end

  assign adv        = pix_en && !frozen;
  assign ax_last[0] = xlast;
  assign ax_last[1] = ylast;
  assign ax_step[0] = adv;
  assign ax_step[1] = adv && ax_end[0];

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    vtp_axis_ctr #(.CW(CW)) i_ctr (
      .clk(clk), .rst_n(rst_n), .clr(cfg_ok),
      .step(ax_step[a]), .last(ax_last[a]),
      .cnt(ax_cnt[a]), .at_last(ax_end[a])
    );
  end

  assign pos_x = ax_cnt[0];
  assign pos_y = ax_cnt[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_start <= 1'b0;
    end else begin
      frame_start <= adv && !cfg_ok && (&ax_end);
    end
  end

  vtp_readback #(.CW(CW), .DW(DW), .AW(AW)) i_rb (
    .addr(bus_addr), .frozen(frozen),
    .pos_x(pos_x), .pos_y(pos_y),
    .xlast(xlast), .ylast(ylast),
    .rdata(bus_rdata)
  );

endmodule

// File: rtl/raster_pos_regs_chk.sv
module raster_pos_regs_chk #(
  parameter int CW = 12,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          cfg_load,
  input logic [CW-1:0] cfg_xres,
  input logic [CW-1:0] cfg_yres,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          frame_start,
  input logic          frozen,
  input logic [CW-1:0] pos_x,
  input logic [CW-1:0] pos_y,
  input logic [CW-1:0] xlast,
  input logic [CW-1:0] ylast
);

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_x <= xlast) && (pos_y <= ylast)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !cfg_load) |=> ($stable(pos_x) && $stable(pos_y))); // R4

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !cfg_load) |=> ($stable(pos_x) && $stable(pos_y))); // R5

  AST_FREEZE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0) |=> (frozen == $past(bus_wdata[31]))); // R5

  AST_FRAME_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (pos_x == '0 && pos_y == '0)); // R9

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_xres != '0 && cfg_yres != '0) |=>
      (pos_x == '0 && pos_y == '0 && xlast == $past(cfg_xres) - CW'(1))); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > AW'(3)) |-> (bus_rdata == '0)); // R11

endmodule

bind raster_pos_regs raster_pos_regs_chk #(.CW(CW), .DW(DW), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_load(cfg_load),
  .cfg_xres(cfg_xres), .cfg_yres(cfg_yres), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .frame_start(frame_start), .frozen(frozen), .pos_x(pos_x),
  .pos_y(pos_y), .xlast(xlast), .ylast(ylast)
);

// File: tb/test_raster_pos_regs.sv
module test_raster_pos_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // entry: {pix_en, expected x, expected y, expected frame_start}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 12'd1, 12'd0, 1'b0},
    {1'b1, 12'd2, 12'd0, 1'b0},
    {1'b0, 12'd2, 12'd0, 1'b0},
    {1'b1, 12'd0, 12'd1, 1'b0},
    {1'b1, 12'd1, 12'd1, 1'b0},
    {1'b1, 12'd2, 12'd1, 1'b0},
    {1'b1, 12'd0, 12'd0, 1'b1},
    {1'b0, 12'd0, 12'd0, 1'b0},
    {1'b1, 12'd1, 12'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic        cfg_load = 1'b0;
  logic [11:0] cfg_xres = '0;
  logic [11:0] cfg_yres = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_start;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  raster_pos_regs i_raster_pos_regs (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_load(cfg_load),
    .cfg_xres(cfg_xres), .cfg_yres(cfg_yres), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_start(frame_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 / R2 / R6 / R7 / R8 reset state
    rd(4'd0, v); chk("R1 pos after reset", v, 32'h0);
    rd(4'd1, v); chk("R6 max after reset", v, 32'h001D_F27F);
    rd(4'd2, v); chk("R7 hwin after reset", v, 32'h0000_027F);
    rd(4'd3, v); chk("R8 vwin after reset", v, 32'h0000_01DF);
    chk("R1 frame_start low", {31'b0, frame_start}, 32'h0);

    // R3 advance across a line at default resolution: 700 steps -> x=60, y=1
    pix_en = 1'b1; cyc(700); pix_en = 1'b0;
    rd(4'd0, v); chk("R3 R2 pos after 700", v, 32'h0000_103C);

    // R4 idle cycles
    cyc(5);
    rd(4'd0, v); chk("R4 pos idle", v, 32'h0000_103C);

    // R5 freeze; low bits of write must not load position
    wr(4'd0, 32'h8000_0ABC);
    pix_en = 1'b1; cyc(5); pix_en = 1'b0;
    rd(4'd0, v); chk("R5 frozen pos", v, 32'h8000_103C);
    wr(4'd0, 32'h0000_0FFF);
    rd(4'd0, v); chk("R5 release keeps pos", v, 32'h0000_103C);
    pix_en = 1'b1; cyc(3); pix_en = 1'b0;
    rd(4'd0, v); chk("R5 resumes", v, 32'h0000_103F);

    // R11 read-only writes ignored, unmapped reads zero
    wr(4'd1, 32'h0);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd9, 32'h8000_0000);
    rd(4'd1, v); chk("R11 max unchanged", v, 32'h001D_F27F);
    rd(4'd2, v); chk("R11 hwin unchanged", v, 32'h0000_027F);
    rd(4'd0, v); chk("R11 no freeze from other offset", v, 32'h0000_103F);
    rd(4'd7, v); chk("R11 unmapped 7", v, 32'h0);
    rd(4'd15, v); chk("R11 unmapped 15", v, 32'h0);

    // R10 zero resolution ignored
    cfg_xres = 12'd0; cfg_yres = 12'd5; cfg_load = 1'b1; cyc(1); cfg_load = 1'b0;
    rd(4'd1, v); chk("R10 zero load ignored", v, 32'h001D_F27F);
    rd(4'd0, v); chk("R10 zero load keeps pos", v, 32'h0000_103F);

    // R10 load 3x2, with pix_en high to show load wins
    cfg_xres = 12'd3; cfg_yres = 12'd2; cfg_load = 1'b1; pix_en = 1'b1;
    cyc(1); cfg_load = 1'b0; pix_en = 1'b0;
    rd(4'd0, v); chk("R10 load clears pos", v, 32'h0);
    rd(4'd1, v); chk("R6 max 3x2", v, 32'h0000_1002);
    rd(4'd2, v); chk("R7 hwin 3x2", v, 32'h0000_0002);
    rd(4'd3, v); chk("R8 vwin 3x2", v, 32'h0000_0001);

    // R3 / R9 vector walk over a 3x2 raster
    for (int k = 0; k < NVEC; k++) begin
      pix_en = VEC[k][25];
      cyc(1);
      rd(4'd0, v);
      chk("R3 vector pos", v, {8'h00, VEC[k][12:1], VEC[k][24:13]});
      chk("R9 vector frame_start", {31'b0, frame_start}, {31'b0, VEC[k][0]});
    end
    pix_en = 1'b0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule